// File: doc/BRIEF.md
# Diagnostic Status Word with Fault Counters

This block keeps one 16-bit diagnostic status word for a supply-management controller. A serial register interface outside the block reads the word. The interface also issues a one-cycle read-and-clear strobe when software performs a clearing read.

The upper byte holds three sticky fault flags and a two-bit wake-source field:
- thermal warning,
- first-level thermal shutdown,
- a filtered supply-fail flag.

The flags stay set until a read-and-clear. The wake-source field reloads only on a read-and-clear.

The lower byte holds two saturating counters that software cannot clear:
- A 3-bit count of second-level thermal shutdowns that restarted the regulator. It returns to zero after a quiet window, measured in timebase ticks, passes with no new event.
- A 4-bit count of missed watchdog triggers. A correct trigger zeroes it.

When either counter reaches its terminal value, the block raises a request that forces the device into deep standby. The request stays high until that counter is zeroed.

The supply-fail flag comes from a small state machine that debounces the supply-low comparator. It has three states:
- `SUP_OK`: the comparator is high.
- `SUP_DIP`: the comparator is low and consecutive low cycles are being counted.
- `SUP_TRIPPED`: the fault has been reported for this low episode.

It moves through these transitions:
- From `SUP_OK` to `SUP_DIP` on the first low sample.
- From `SUP_DIP` back to `SUP_OK` if the comparator releases early.
- From `SUP_DIP` to `SUP_TRIPPED` on the low sample that completes the filter time. This transition emits the trip.
- From `SUP_TRIPPED` to `SUP_OK` when the comparator releases.

Top module: `diag_status_reg`

## Requirements
- R1: After reset, `status_o` reads 0x0000 and `force_stby_o` is low.
- R2: A pulse on `therm_warn_i` sets bit 15, and a pulse on `therm_sd1_i` sets bit 14. Each bit stays set until a cycle with `rd_clr_i` high, and it reads 0 from the following cycle.
- R3: If a fault pulse arrives in the same cycle as `rd_clr_i`, its flag is still set afterwards.
- R4: Bit 13 (supply fail) sets only when `vbat_low_i` is high for FILT_CYCLES+1 consecutive cycles. Shorter dips leave it at 0. Once set, it stays set until `rd_clr_i`. One low episode sets it at most once.
- R5: Bits 12:11 take the value of `wake_src_i` only in a cycle with `rd_clr_i` high, and hold between such cycles. Code 01 means battery-supplied standby and 10 means regulator-on standby.
- R6: Bits 6:4 count `therm_sd2_i` pulses. The count saturates at 7 and is not changed by `rd_clr_i`.
- R7: The bits 6:4 count returns to 0 on the QUIET_TICKS-th `tick_i` after the latest `therm_sd2_i` pulse. A `therm_sd2_i` pulse, including one in the same cycle as a tick, restarts that window.
- R8: Bits 3:0 count `wd_miss_i` pulses. The count saturates at 15 and is not changed by `rd_clr_i`.
- R9: `wd_ok_i` zeroes bits 3:0. It takes priority over a `wd_miss_i` in the same cycle.
- R10: `force_stby_o` is high exactly when bits 6:4 equal 7 or bits 3:0 equal 15.
- R11: Bits 10:7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_warn_i | input | 1 | Thermal warning event pulse |
| therm_sd1_i | input | 1 | First-level thermal shutdown pulse |
| therm_sd2_i | input | 1 | Second-level shutdown with regulator restart pulse |
| vbat_low_i | input | 1 | Supply-low comparator output |
| wake_src_i | input | 2 | Low-power state the device woke from |
| wd_ok_i | input | 1 | Correct watchdog trigger strobe |
| wd_miss_i | input | 1 | Missed watchdog trigger strobe |
| tick_i | input | 1 | Slow timebase tick |
| rd_clr_i | input | 1 | Read-and-clear access strobe |
| status_o | output | 16 | Diagnostic status word |
| force_stby_o | output | 1 | Deep-standby force request |

## Verification
Every flag and counter is one register behind its input. A pulse applied before a clock edge therefore appears in `status_o` right after that edge. `force_stby_o` follows the counters combinationally in that same cycle. The supply-fail flag appears just after the edge that samples the (FILT_CYCLES+1)-th consecutive low. The bench drives inputs a quarter period after a rising edge, advances exactly one edge per step, and samples at that same quarter point, so each result is read in its first valid cycle. The expected values come from counters kept in the bench, such as the number of pulses and ticks applied, using saturating arithmetic.

// File: rtl/diag_pkg.sv
package diag_pkg;
    localparam int RST_W = 3;
    localparam int WD_W  = 4;

    typedef enum logic [1:0] {
        SUP_OK      = 2'd0,
        SUP_DIP     = 2'd1,
        SUP_TRIPPED = 2'd2
    } sup_state_t;
endpackage

// File: rtl/diag_vbat_filter.sv
module diag_vbat_filter
    import diag_pkg::*;
#(
    parameter int FILT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    output logic trip_o
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    sup_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SUP_OK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        trip_o  = 1'b0;
        unique case (state_q)
            SUP_OK: begin
                if (low_i) begin
                    state_d = SUP_DIP;
                    cnt_d   = CW'(1);
                end
            end
            SUP_DIP: begin
                if (!low_i) begin
                    state_d = SUP_OK;
                end else if (cnt_q == CW'(FILT_CYCLES)) begin
                    state_d = SUP_TRIPPED;
                    trip_o  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            SUP_TRIPPED: begin
                if (!low_i) state_d = SUP_OK;
            end
            default: state_d = SUP_OK;
        endcase
    end

    a_r4_trip_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        trip_o |-> low_i);
    a_r4_dip_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_DIP) |-> $past(low_i));
endmodule

// File: rtl/diag_sat_counter.sv
module diag_sat_counter #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_o <= '0;
        else if (clr_i)                 cnt_o <= '0;
        else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + W'(1);
    end

    assign full_o = (cnt_o == TOP);

    a_r6_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !clr_i) |=> full_o);
    a_r7_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/diag_quiet_timer.sv
module diag_quiet_timer #(
    parameter int QUIET_TICKS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic restart_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int QW = $clog2(QUIET_TICKS + 1);

    logic [QW-1:0] ticks_q;

    assign expire_o = active_i && tick_i && !restart_i
                      && (ticks_q == QW'(QUIET_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    ticks_q <= '0;
        else if (restart_i || !active_i) ticks_q <= '0;
        else if (expire_o)             ticks_q <= '0;
        else if (tick_i)               ticks_q <= ticks_q + QW'(1);
    end

    a_r7_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> tick_i);
endmodule

// File: rtl/diag_status_reg.sv
module diag_status_reg
    import diag_pkg::*;
#(
    parameter int FILT_CYCLES = 8,
    parameter int QUIET_TICKS = 60
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        therm_warn_i,
    input  logic        therm_sd1_i,
    input  logic        therm_sd2_i,
    input  logic        vbat_low_i,
    input  logic [1:0]  wake_src_i,
    input  logic        wd_ok_i,
    input  logic        wd_miss_i,
    input  logic        tick_i,
    input  logic        rd_clr_i,
    output logic [15:0] status_o,
    output logic        force_stby_o
);
    logic             tw_q, sd1_q, vfail_q;
    logic [1:0]       wake_q;
    logic             vbat_trip;
    logic             quiet_expire;
    logic [RST_W-1:0] rst_cnt;
    logic [WD_W-1:0]  wd_cnt;
    logic             rst_full, wd_full;

    diag_vbat_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk(clk), .rst_n(rst_n), .low_i(vbat_low_i), .trip_o(vbat_trip)
    );

    diag_quiet_timer #(.QUIET_TICKS(QUIET_TICKS)) u_quiet (
        .clk(clk), .rst_n(rst_n), .active_i(rst_cnt != '0),
        .restart_i(therm_sd2_i), .tick_i(tick_i), .expire_o(quiet_expire)
    );

    diag_sat_counter #(.W(RST_W)) u_rst_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(therm_sd2_i), .clr_i(quiet_expire),
        .cnt_o(rst_cnt), .full_o(rst_full)
    );

    diag_sat_counter #(.W(WD_W)) u_wd_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(wd_miss_i), .clr_i(wd_ok_i),
        .cnt_o(wd_cnt), .full_o(wd_full)
    );

    // sticky flags: a new event outranks a clearing read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_q    <= 1'b0;
            sd1_q   <= 1'b0;
            vfail_q <= 1'b0;
            wake_q  <= 2'b00;
        end else begin
            tw_q    <= therm_warn_i | (tw_q    & ~rd_clr_i);
            sd1_q   <= therm_sd1_i  | (sd1_q   & ~rd_clr_i);
            vfail_q <= vbat_trip    | (vfail_q & ~rd_clr_i);
            if (rd_clr_i) wake_q <= wake_src_i;
        end
    end

    assign status_o     = {tw_q, sd1_q, vfail_q, wake_q, 4'b0000, rst_cnt, wd_cnt};
    assign force_stby_o = rst_full | wd_full;

    a_r2_warn_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_q && !rd_clr_i) |=> tw_q);
    a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_sd1_i && rd_clr_i) |=> sd1_q);
    a_r5_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> $stable(wake_q));
    a_r7_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_cnt != '0) |-> $past(tick_i));
    a_r10_force_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(force_stby_o) |-> $past(therm_sd2_i || wd_miss_i));
endmodule

// File: tb/diag_status_reg_tb.sv
module diag_status_reg_tb;
    localparam int CLK_P = 10;
    localparam int FILT  = 3;
    localparam int QUIET = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tw = 0, sd1 = 0, sd2 = 0, vlow = 0, wdok = 0, miss = 0, tick = 0, rc = 0;
    logic [1:0] wake = 2'b00;
    logic [15:0] st;
    logic force_o;
    int nchk = 0;
    int nerr = 0;

    always #(CLK_P/2) clk = ~clk;

    diag_status_reg #(.FILT_CYCLES(FILT), .QUIET_TICKS(QUIET)) u_dut (
        .clk(clk), .rst_n(rst_n), .therm_warn_i(tw), .therm_sd1_i(sd1),
        .therm_sd2_i(sd2), .vbat_low_i(vlow), .wake_src_i(wake), .wd_ok_i(wdok),
        .wd_miss_i(miss), .tick_i(tick), .rd_clr_i(rc),
        .status_o(st), .force_stby_o(force_o)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one edge; pulse inputs drop afterwards
    task automatic cyc();
        @(posedge clk);
        #(CLK_P/4);
        tw = 0; sd1 = 0; sd2 = 0; wdok = 0; miss = 0; tick = 0; rc = 0;
    endtask

    task automatic chk_force();
        check("R10 force", int'(force_o),
              int'(st[6:4] == 3'd7 || st[3:0] == 4'd15));
    endtask

    initial begin
        #(CLK_P * 200000);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(CLK_P*2 + CLK_P/4);
        check("R1 word", int'(st), 0);
        check("R1 force", int'(force_o), 0);
        rst_n = 1'b1;
        cyc();
        check("R1 word after release", int'(st), 0);
        check("R11 pad", int'(st[10:7]), 0);

        // R2 sticky flags
        tw = 1; cyc();
        check("R2 warn set", int'(st[15]), 1);
        cyc(); cyc();
        check("R2 warn held", int'(st[15]), 1);
        rc = 1; cyc();
        check("R2 warn cleared", int'(st[15]), 0);
        sd1 = 1; cyc();
        check("R2 sd1 set", int'(st[14]), 1);
        rc = 1; cyc();
        check("R2 sd1 cleared", int'(st[14]), 0);
        // R3 event with clear
        tw = 1; rc = 1; cyc();
        check("R3 warn wins", int'(st[15]), 1);
        sd1 = 1; rc = 1; cyc();
        check("R3 sd1 wins", int'(st[14]), 1);
        check("R3 warn cleared beside", int'(st[15]), 0);
        rc = 1; cyc();

        // R5 wake field
        wake = 2'b01; cyc();
        check("R5 no load without clear", int'(st[12:11]), 0);
        rc = 1; cyc();
        check("R5 load 01", int'(st[12:11]), 1);
        wake = 2'b10; cyc(); cyc();
        check("R5 hold", int'(st[12:11]), 1);
        rc = 1; cyc();
        check("R5 load 10", int'(st[12:11]), 2);

        // R4 supply filter sweep
        for (int len = 1; len <= 6; len++) begin
            rc = 1; cyc();
            vlow = 1;
            for (int k = 0; k < len; k++) cyc();
            vlow = 0; cyc();
            check($sformatf("R4 dip len %0d", len), int'(st[13]), int'(len >= FILT + 1));
        end
        cyc();
        check("R4 latched", int'(st[13]), 1);
        // long low: single set per episode
        rc = 1; cyc();
        vlow = 1;
        for (int k = 0; k < 6; k++) cyc();
        rc = 1; cyc(); cyc(); cyc();
        check("R4 one set per episode", int'(st[13]), 0);
        vlow = 0; cyc();
        rc = 1; cyc();

        // R6 restart count sweep
        for (int n = 1; n <= 9; n++) begin
            sd2 = 1; cyc();
            check($sformatf("R6 count after %0d", n), int'(st[6:4]), (n > 7) ? 7 : n);
            chk_force();
        end
        rc = 1; cyc();
        check("R6 clear read ignored", int'(st[6:4]), 7);
        // R7 quiet window
        for (int t = 1; t < QUIET; t++) begin tick = 1; cyc(); cyc(); end
        check("R7 before window", int'(st[6:4]), 7);
        sd2 = 1; tick = 1; cyc();
        check("R7 event with tick", int'(st[6:4]), 7);
        for (int t = 1; t < QUIET; t++) begin tick = 1; cyc(); end
        check("R7 window restarted", int'(st[6:4]), 7);
        tick = 1; cyc();
        check("R7 cleared", int'(st[6:4]), 0);
        chk_force();
        sd2 = 1; cyc(); sd2 = 1; cyc();
        for (int t = 1; t <= QUIET; t++) begin
            tick = 1; cyc();
            check($sformatf("R7 tick %0d", t), int'(st[6:4]), (t == QUIET) ? 0 : 2);
        end

        // R8 watchdog count sweep
        for (int n = 1; n <= 17; n++) begin
            miss = 1; cyc();
            check($sformatf("R8 misses %0d", n), int'(st[3:0]), (n > 15) ? 15 : n);
            chk_force();
        end
        rc = 1; cyc();
        check("R8 clear read ignored", int'(st[3:0]), 15);
        check("R10 force from wd", int'(force_o), 1);
        wdok = 1; cyc();
        check("R9 ok zeroes", int'(st[3:0]), 0);
        check("R10 force drops", int'(force_o), 0);
        miss = 1; cyc(); miss = 1; cyc();
        miss = 1; wdok = 1; cyc();
        check("R9 ok beats miss", int'(st[3:0]), 0);
        miss = 1; cyc();
        check("R9 counts again", int'(st[3:0]), 1);
        check("R11 pad end", int'(st[10:7]), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule